// File: doc/BRIEF.md
# Channel Clock Source Switch Sequencer

This block sits beside the command-issue path of a two-channel ATA controller. When a command is offered it decides which clock the ATA bus should run from: the PLL-derived clock or the host bus clock. Writes always need the PLL clock. When the host bus runs at 66 MHz, every command needs it. All other commands use the host bus clock.

A source change is attempted only when the partner channel's protocol engine is idle and the wanted source differs from the current one. The change runs as an ordered sequence with these steps:
- isolate both channels from the bus;
- select the new source;
- hold the channel reset;
- reset both protocol state machines;
- release the channel reset;
- reconnect both channels.

Every step lasts `STEP_CYC` cycles. The command is granted in the last reconnect cycle. When no change is needed, the grant is given in the same cycle as the request.

States:
- `ST_IDLE` waits for a request.
- `ST_ISOLATE`, `ST_SELECT`, `ST_CHRST`, `ST_SMRST`, `ST_RELEASE` and `ST_RECONNECT` are the six steps, in that order.

Transitions:
- idle to isolate, on a request that needs a switch;
- each step to the next, when its step timer expires;
- reconnect back to idle, with the grant.

Top module: `clksw_seq`

## Requirements
- R1: In reset and after it, `tri_a`/`tri_b` are 0x00, `src_sel` is 0x23 (host bus clock), `chan_rst` is 0x00, `smrst_a`/`smrst_b` are 0x00 and `issue_grant` is 0.
- R2: The wanted source is the PLL (0x21) when `issue_write` or `bus_66m` is 1, and the host bus clock (0x23) otherwise; after a switch `src_sel` shows the wanted code.
- R3: When `partner_idle` is 0, no switch starts: `issue_grant` is 1 in the request cycle and `src_sel` keeps its value.
- R4: When the wanted source equals the current one, `issue_grant` is 1 in the request cycle and no other output changes.
- R5: A switch drives, in order, these steps:
  - isolate: tri 0x80 on both channels;
  - select: new `src_sel`;
  - channel reset: `chan_rst` 0xC0;
  - state machine reset: `chan_rst` 0xC0 and `smrst_a`/`smrst_b` 0x37;
  - release: `chan_rst` 0x00, tri still 0x80;
  - reconnect: tri 0x00.
- R6: Each step of a switch lasts exactly `STEP_CYC` cycles (default 4), starting the cycle after the request.
- R7: During a switch, `issue_grant` is 1 only in the last reconnect cycle, and the grant is never asserted while a channel is isolated.
- R8: The current-source register changes on entry to the select step; `src_sel` keeps the old code through the isolate step and changes only while both channels are isolated.
- R9: Request strobes that arrive while a switch is running are ignored: they cause no extra grant and do not alter the sequence.
- R10: The state machine reset code is driven only while the channel reset is held and both channels are isolated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | Command issue strobe |
| issue_write | input | 1 | Pending command is a write |
| bus_66m | input | 1 | Host bus runs at 66 MHz |
| partner_idle | input | 1 | Partner channel protocol engine is idle |
| tri_a | output | 8 | Channel A bus isolation code (0x80 isolate, 0x00 connect) |
| tri_b | output | 8 | Channel B bus isolation code |
| src_sel | output | 8 | Clock source code (0x21 PLL, 0x23 host bus) |
| chan_rst | output | 8 | Channel reset code (0xC0 held, 0x00 released) |
| smrst_a | output | 8 | Channel A state machine reset code (0x37 reset, 0x00 none) |
| smrst_b | output | 8 | Channel B state machine reset code |
| issue_grant | output | 1 | Command may be issued |

## Verification
The hardest situation to reach is a second request strobe in the middle of a running switch. It must leave the remaining steps, their lengths and the single grant untouched. The stimulus reaches it this way: a switch is started, two cycles into the isolate step the driver pulses the request again with a flipped write flag, and the scoreboard still expects the undisturbed trace. A second hard case is a request that would need a switch while the partner is busy. That needs a current source different from the wanted one, so the bench first switches to the PLL and then offers a read with the partner busy.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ISOLATE   = 3'd1,
        ST_SELECT    = 3'd2,
        ST_CHRST     = 3'd3,
        ST_SMRST     = 3'd4,
        ST_RELEASE   = 3'd5,
        ST_RECONNECT = 3'd6
    } seq_state_t;

    localparam logic [7:0] CODE_SRC_PLL   = 8'h21;
    localparam logic [7:0] CODE_SRC_HOST  = 8'h23;
    localparam logic [7:0] CODE_CHRST_ON  = 8'hC0;
    localparam logic [7:0] CODE_CHRST_OFF = 8'h00;
    localparam logic [7:0] CODE_SMRST     = 8'h37;
    localparam logic [7:0] CODE_TRI_ISO   = 8'h80;
    localparam logic [7:0] CODE_TRI_CONN  = 8'h00;
endpackage

// File: rtl/clksw_policy.sv
module clksw_policy (
    input  logic issue_write,
    input  logic bus_66m,
    input  logic partner_idle,
    input  logic cur_pll,
    output logic want_pll,
    output logic need_switch
);
    // PLL is required for writes and for every command on a 66 MHz host bus
    always_comb begin
        want_pll    = issue_write | bus_66m;
        need_switch = partner_idle & (want_pll != cur_pll);
    end
endmodule

// File: rtl/clksw_step_timer.sv
module clksw_step_timer #(
    parameter int STEP_CYC = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   run,
    input  logic                                   advance,
    output logic [$clog2(STEP_CYC + 1) - 1:0]      step_cnt,
    output logic                                   step_done
);
    localparam int CW = $clog2(STEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || advance)
            step_cnt <= '0;
        else if (step_cnt != LAST)
            step_cnt <= step_cnt + 1'b1;
    end

    assign step_done = run && (step_cnt == LAST);
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
    import clksw_pkg::*;
#(
    parameter int STEP_CYC = 4,
    localparam int CW = $clog2(STEP_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_req,
    input  logic          need_switch,
    input  logic          want_pll,
    input  logic          step_done,
    input  logic [CW-1:0] step_cnt,
    output logic          cur_pll,
    output logic          run,
    output logic          advance,
    output logic [7:0]    tri_a,
    output logic [7:0]    tri_b,
    output logic [7:0]    src_sel,
    output logic [7:0]    chan_rst,
    output logic [7:0]    smrst_a,
    output logic [7:0]    smrst_b,
    output logic          issue_grant
);
    seq_state_t state, state_nx;
    logic       target_pll;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (issue_req && need_switch) state_nx = ST_ISOLATE;
            ST_ISOLATE:   if (step_done) state_nx = ST_SELECT;
            ST_SELECT:    if (step_done) state_nx = ST_CHRST;
            ST_CHRST:     if (step_done) state_nx = ST_SMRST;
            ST_SMRST:     if (step_done) state_nx = ST_RELEASE;
            ST_RELEASE:   if (step_done) state_nx = ST_RECONNECT;
            ST_RECONNECT: if (step_done) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register, latched target and current source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            target_pll <= 1'b0;
            cur_pll    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && issue_req && need_switch)
                target_pll <= want_pll;
            if (state == ST_ISOLATE && step_done)
                cur_pll <= target_pll;
        end
    end

    // outputs
    always_comb begin
        run         = (state != ST_IDLE);
        advance     = step_done;
        tri_a       = CODE_TRI_CONN;
        chan_rst    = CODE_CHRST_OFF;
        smrst_a     = 8'h00;
        issue_grant = 1'b0;
        unique case (state)
            ST_IDLE:      issue_grant = issue_req && !need_switch;
            ST_ISOLATE,
            ST_SELECT,
            ST_RELEASE:   tri_a = CODE_TRI_ISO;
            ST_CHRST: begin
                tri_a    = CODE_TRI_ISO;
                chan_rst = CODE_CHRST_ON;
            end
            ST_SMRST: begin
                tri_a    = CODE_TRI_ISO;
                chan_rst = CODE_CHRST_ON;
                smrst_a  = CODE_SMRST;
            end
            ST_RECONNECT: issue_grant = step_done;
            default: ;
        endcase
        tri_b   = tri_a;
        smrst_b = smrst_a;
        src_sel = cur_pll ? CODE_SRC_PLL : CODE_SRC_HOST;
    end

    AST_SMRST_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (smrst_a != 8'h00 || smrst_b != 8'h00) |-> (chan_rst == CODE_CHRST_ON && tri_a == CODE_TRI_ISO && tri_b == CODE_TRI_ISO)); // R10
    AST_SRC_CHANGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel) |-> (tri_a == CODE_TRI_ISO && tri_b == CODE_TRI_ISO)); // R8
    AST_GRANT_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> (tri_a == CODE_TRI_CONN && chan_rst == CODE_CHRST_OFF)); // R7
    AST_STEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && state != $past(state)) |-> ($past(step_cnt) == CW'(STEP_CYC - 1))); // R6
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_IDLE && $past(state) != ST_RECONNECT && state != $past(state))
            |-> (3'(state) == 3'($past(state)) + 3'd1)); // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISOLATE && $past(state) == ST_ISOLATE) |-> $stable(target_pll)); // R9
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq #(
    parameter int STEP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_req,
    input  logic       issue_write,
    input  logic       bus_66m,
    input  logic       partner_idle,
    output logic [7:0] tri_a,
    output logic [7:0] tri_b,
    output logic [7:0] src_sel,
    output logic [7:0] chan_rst,
    output logic [7:0] smrst_a,
    output logic [7:0] smrst_b,
    output logic       issue_grant
);
    localparam int CW = $clog2(STEP_CYC + 1);

    logic          cur_pll, want_pll, need_switch;
    logic          run, advance, step_done;
    logic [CW-1:0] step_cnt;

    clksw_policy u_policy (
        .issue_write (issue_write),
        .bus_66m     (bus_66m),
        .partner_idle(partner_idle),
        .cur_pll     (cur_pll),
        .want_pll    (want_pll),
        .need_switch (need_switch)
    );

    clksw_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .advance  (advance),
        .step_cnt (step_cnt),
        .step_done(step_done)
    );

    clksw_fsm #(.STEP_CYC(STEP_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_req  (issue_req),
        .need_switch(need_switch),
        .want_pll   (want_pll),
        .step_done  (step_done),
        .step_cnt   (step_cnt),
        .cur_pll    (cur_pll),
        .run        (run),
        .advance    (advance),
        .tri_a      (tri_a),
        .tri_b      (tri_b),
        .src_sel    (src_sel),
        .chan_rst   (chan_rst),
        .smrst_a    (smrst_a),
        .smrst_b    (smrst_b),
        .issue_grant(issue_grant)
    );
endmodule

// File: tb/clksw_seq_tb_top.sv
module clksw_seq_tb_top;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_req = 1'b0, issue_write = 1'b0, bus_66m = 1'b0, partner_idle = 1'b1;
    logic [7:0] tri_a, tri_b, src_sel, chan_rst, smrst_a, smrst_b;
    logic issue_grant;

    always #10 clk = ~clk;

    clksw_seq #(.STEP_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_write(issue_write),
        .bus_66m(bus_66m), .partner_idle(partner_idle), .tri_a(tri_a), .tri_b(tri_b),
        .src_sel(src_sel), .chan_rst(chan_rst), .smrst_a(smrst_a), .smrst_b(smrst_b),
        .issue_grant(issue_grant)
    );

    typedef struct packed {
        logic [7:0] tri_v;
        logic [7:0] src;
        logic [7:0] chr;
        logic [7:0] smr;
        logic       gnt;
        logic [3:0] tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    logic model_pll = 1'b0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    function automatic exp_t mk(logic [7:0] t, logic [7:0] s, logic [7:0] c,
                                logic [7:0] m, logic g, logic [3:0] tag);
        exp_t e;
        e.tri_v = t; e.src = s; e.chr = c; e.smr = m; e.gnt = g; e.tag = tag;
        return e;
    endfunction

    function automatic logic [7:0] code(logic pll);
        return pll ? 8'h21 : 8'h23;
    endfunction

    task automatic cmp(string what, int tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: pops one expected item per cycle, idle expectation when empty
    always @(negedge clk) begin
        if (mon_en) begin
            exp_t e;
            if (q.size() > 0) e = q.pop_front();
            else e = mk(8'h00, code(model_pll), 8'h00, 8'h00, 1'b0, 4'd4);
            cmp("tri_a", int'(e.tag), tri_a, e.tri_v);
            cmp("tri_b", int'(e.tag), tri_b, e.tri_v);
            cmp("src_sel", int'(e.tag), src_sel, e.src);
            cmp("chan_rst", int'(e.tag), chan_rst, e.chr);
            cmp("smrst_a", int'(e.tag), smrst_a, e.smr);
            cmp("smrst_b", int'(e.tag), smrst_b, e.smr);
            cmp("issue_grant", int'(e.tag), {7'd0, issue_grant}, {7'd0, e.gnt});
        end
    end

    // driver: offers one command and pushes the expected per-cycle trace
    task automatic issue(logic w, logic f66, logic pidle, logic [3:0] tag, logic poke);
        logic want, sw, newp;
        @(posedge clk); #1;
        issue_req = 1'b1; issue_write = w; bus_66m = f66; partner_idle = pidle;
        want = w | f66;
        sw = pidle && (want != model_pll);
        if (!sw) begin
            q.push_back(mk(8'h00, code(model_pll), 8'h00, 8'h00, 1'b1, tag)); // R3 / R4
        end else begin
            newp = want;
            q.push_back(mk(8'h00, code(model_pll), 8'h00, 8'h00, 1'b0, poke ? 4'd9 : 4'd6));
            for (int k = 0; k < S; k++) // isolate: old source kept, R8
                q.push_back(mk(8'h80, code(model_pll), 8'h00, 8'h00, 1'b0, poke ? 4'd9 : 4'd8));
            for (int k = 0; k < S; k++) // select: policy source, R2
                q.push_back(mk(8'h80, code(newp), 8'h00, 8'h00, 1'b0, poke ? 4'd9 : 4'd2));
            for (int k = 0; k < S; k++) // channel reset, R5
                q.push_back(mk(8'h80, code(newp), 8'hC0, 8'h00, 1'b0, poke ? 4'd9 : 4'd5));
            for (int k = 0; k < S; k++) // state machine reset, R10
                q.push_back(mk(8'h80, code(newp), 8'hC0, 8'h37, 1'b0, poke ? 4'd9 : 4'd10));
            for (int k = 0; k < S; k++) // release, R6
                q.push_back(mk(8'h80, code(newp), 8'h00, 8'h00, 1'b0, poke ? 4'd9 : 4'd6));
            for (int k = 0; k < S; k++) // reconnect, grant in last cycle, R7
                q.push_back(mk(8'h00, code(newp), 8'h00, 8'h00, k == S - 1, poke ? 4'd9 : 4'd7));
            model_pll = newp;
        end
        @(posedge clk); #1;
        issue_req = 1'b0;
        if (poke && sw) begin
            @(posedge clk); #1;
            issue_req = 1'b1; issue_write = ~w; // R9: strobe mid-sequence
            @(posedge clk); #1;
            issue_req = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        cmp("tri_a", 1, tri_a, 8'h00);
        cmp("src_sel", 1, src_sel, 8'h23);
        cmp("chan_rst", 1, chan_rst, 8'h00);
        cmp("smrst_a", 1, smrst_a, 8'h00);
        cmp("issue_grant", 1, {7'd0, issue_grant}, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        cmp("src_sel", 1, src_sel, 8'h23); // R1 after release
        mon_en = 1'b1;

        issue(1'b0, 1'b0, 1'b1, 4'd4, 1'b0); // read, host already: R4
        issue(1'b1, 1'b0, 1'b1, 4'd5, 1'b0); // write: switch to PLL, R2 R5
        issue(1'b1, 1'b0, 1'b1, 4'd4, 1'b0); // write again: R4
        issue(1'b0, 1'b0, 1'b0, 4'd3, 1'b0); // read, partner busy: R3
        issue(1'b0, 1'b0, 1'b1, 4'd5, 1'b0); // read: switch to host, R2
        issue(1'b0, 1'b1, 1'b1, 4'd5, 1'b0); // 66 MHz read: PLL, R2
        issue(1'b0, 1'b1, 1'b1, 4'd4, 1'b0); // 66 MHz read again: R4
        issue(1'b0, 1'b0, 1'b1, 4'd9, 1'b1); // switch to host with mid strobe: R9
        issue(1'b1, 1'b0, 1'b0, 4'd3, 1'b0); // write, partner busy: R3
        issue(1'b1, 1'b1, 1'b1, 4'd5, 1'b0); // write on 66 MHz: PLL
        issue(1'b0, 1'b0, 1'b1, 4'd5, 1'b0); // back to host
        repeat (4) @(posedge clk);
        mon_en = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule